// File: doc/BRIEF.md
# ADC conversion timing sequencer

This block produces the digital timing for a successive-approximation analog-to-digital converter. A programmable prescaler divides the module clock down to a basic conversion clock. The sequencer then holds a sample phase whose length is a multiple of four basic clocks. After that it resolves the result one bit per basic clock, starting at the most significant bit. The analog comparator lives outside the block. It is seen as a one-bit input that answers the trial code the block presents.

Two timing profiles are supplied as 13-bit words: one for standard conversions and one for injected conversions. Each word carries a divider, a sample count and a resolution select (10 or 8 bits). The block copies the chosen profile when it accepts a start request. It reports a sample-phase flag and a busy flag. It emits a one-cycle completion pulse together with a right-aligned result. A mode bit is held alongside the sequencer, and a write to it is refused while a conversion runs.

Top module: `adc_seq_timer`

## Requirements
- R1: While reset is asserted, and until the first start after reset, busy, sample and done read 0, and the result, the trial code and the mode bit read 0.
- R2: A start request is accepted only in a cycle where busy is 0. A request made while busy changes neither the running conversion's length nor its result.
- R3: A profile word holds the divider D in bits 11:6 and the sample count S in bits 5:0. The sample flag rises in the cycle after acceptance and stays high for exactly 4·(S+1)·(D+1) module-clock cycles.
- R4: Busy rises together with the sample flag. It stays high for (4·(S+1)+N)·(D+1) cycles in total, where N is the number of result bits, so every resolution step lasts D+1 cycles.
- R5: The steps run from the most significant bit downward. Each step presents the trial code (the bits resolved so far plus the bit under test) and keeps that bit when the comparator input is 1. The trial code is 0 outside the stepping phase. If the comparator reports whether an analog value V is at least the trial code, the result equals V.
- R6: Bit 12 of a profile word selects the resolution: 0 gives 10 bits, 1 gives 8 bits. An 8-bit result sits in bits 7:0 with bits 9:8 at 0, so an analog value above 255 yields 255.
- R7: A standard start takes the standard word and an injected start takes the injected word. When both arrive in the same cycle the injected profile wins. The injected-active output is 1 while a conversion using the injected profile is busy.
- R8: The profile is copied at acceptance. Changes to either word during a conversion do not alter its timing or resolution.
- R9: Done is high for exactly one cycle, the first cycle in which busy is 0 again. The result changes only in that cycle and holds until the next done.
- R10: A mode write is taken only when busy is 0. A write while busy leaves the mode bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| std_timing | input | 13 | Standard profile: resolution bit 12, divider 11:6, sample count 5:0 |
| inj_timing | input | 13 | Injected profile, same layout |
| start_std | input | 1 | Request a standard conversion |
| start_inj | input | 1 | Request an injected conversion |
| mode_wr | input | 1 | Write strobe for the mode bit |
| mode_wdata | input | 1 | New value of the mode bit |
| cmp_in | input | 1 | Comparator answer to the current trial code |
| mode_o | output | 1 | Mode bit |
| busy_o | output | 1 | Conversion in progress |
| sample_o | output | 1 | Sample phase in progress |
| inj_active_o | output | 1 | Running conversion uses the injected profile |
| done_o | output | 1 | One-cycle completion pulse |
| sar_code_o | output | 10 | Trial code for the comparator's reference |
| result_o | output | 10 | Right-aligned conversion result |

## Verification
A prescaler that drifts shows up at once in the lengths of the sample and busy windows, which are counted to the exact cycle for each conversion. A sample counter or step index that is off by one moves the falling edge of the sample flag or of busy by a whole basic clock, within that same conversion. A wrong trial code or a bit kept at the wrong time gives a result that differs from the modelled analog value at the next done. Stale or early profile copying, and mode writes that are not blocked, show in the timing or the mode bit of the conversion during which the bench disturbs the inputs.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_CONV   = 2'd2
  } phase_e;
endpackage

// File: rtl/adc_bc_prescaler.sv
// Basic conversion clock: one tick every (div_lim+1) module cycles while run.
module adc_bc_prescaler #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_lim,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  always_comb begin
    wrap  = (cnt_q == div_lim);
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run & wrap;
endmodule

// File: rtl/adc_phase_ctrl.sv
// Phase sequencing: idle -> sample (counted in ticks) -> one step per bit.
module adc_phase_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             tick,
  input  logic [CNT_W-1:0] smp_lim,
  input  logic [IDX_W-1:0] msb_idx,
  output phase_e           phase,
  output logic [IDX_W-1:0] step_idx,
  output logic             step_tick,
  output logic             last_step
);
  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] scnt_q, scnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    phase_d = phase_q;
    scnt_d  = scnt_q;
    idx_d   = idx_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (accept) begin
          phase_d = PH_SAMPLE;
          scnt_d  = '0;
        end
      end
      PH_SAMPLE: begin
        if (tick) begin
          if (scnt_q == smp_lim) begin
            phase_d = PH_CONV;
            idx_d   = msb_idx;
          end else begin
            scnt_d = scnt_q + 1'b1;
          end
        end
      end
      PH_CONV: begin
        if (tick) begin
          if (idx_q == '0) phase_d = PH_IDLE;
          else             idx_d   = idx_q - 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      scnt_q  <= '0;
      idx_q   <= '0;
    end else begin
      phase_q <= phase_d;
      scnt_q  <= scnt_d;
      idx_q   <= idx_d;
    end
  end

  assign phase     = phase_q;
  assign step_idx  = idx_q;
  assign step_tick = (phase_q == PH_CONV) && tick;
  assign last_step = step_tick && (idx_q == '0);
endmodule

// File: rtl/adc_sar_reg.sv
// Successive-approximation register, trial code and result capture.
module adc_sar_reg #(
  parameter int RES_W = 10,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             active,
  input  logic             step_tick,
  input  logic             last_step,
  input  logic [IDX_W-1:0] idx,
  input  logic             cmp,
  output logic [RES_W-1:0] trial,
  output logic [RES_W-1:0] result,
  output logic             done
);
  logic [RES_W-1:0] code_q, code_d, res_q, res_d, bit_sel;
  logic             done_q, done_d;

  always_comb begin
    bit_sel = '0;
    bit_sel[idx] = 1'b1;
    trial  = active ? (code_q | bit_sel) : '0;
    code_d = code_q;
    if (clear)          code_d = '0;
    else if (step_tick) code_d = cmp ? (code_q | bit_sel) : code_q;
    res_d  = last_step ? code_d : res_q;
    done_d = last_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      code_q <= code_d;
      res_q  <= res_d;
      done_q <= done_d;
    end
  end

  assign result = res_q;
  assign done   = done_q;
endmodule

// File: rtl/adc_seq_timer.sv
// Top: reset release, start arbitration, profile capture, mode bit.
module adc_seq_timer
  import adc_seq_pkg::*;
#(
  parameter int DIV_W    = 6,
  parameter int SMP_W    = 6,
  parameter int RES_HI   = 10,
  parameter int RES_LO   = 8,
  parameter int SMP_UNIT = 4   // power of two
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [DIV_W+SMP_W:0]         std_timing,
  input  logic [DIV_W+SMP_W:0]         inj_timing,
  input  logic                         start_std,
  input  logic                         start_inj,
  input  logic                         mode_wr,
  input  logic                         mode_wdata,
  input  logic                         cmp_in,
  output logic                         mode_o,
  output logic                         busy_o,
  output logic                         sample_o,
  output logic                         inj_active_o,
  output logic                         done_o,
  output logic [RES_HI-1:0]            sar_code_o,
  output logic [RES_HI-1:0]            result_o
);
  localparam int CFG_W  = 1 + DIV_W + SMP_W;
  localparam int UNIT_W = $clog2(SMP_UNIT);
  localparam int CNT_W  = SMP_W + UNIT_W;
  localparam int IDX_W  = $clog2(RES_HI);
  localparam logic [CNT_W:0]   ONE_W  = 1;
  localparam logic [IDX_W-1:0] MSB_HI = IDX_W'(RES_HI - 1);
  localparam logic [IDX_W-1:0] MSB_LO = IDX_W'(RES_LO - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  phase_e           phase;
  logic             busy, accept, tick, step_tick, last_step;
  logic [IDX_W-1:0] step_idx;
  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic             inj_q, inj_d, mode_q, mode_d;
  logic             res8;
  logic [DIV_W-1:0] div_lim;
  logic [SMP_W-1:0] smp_cnt;
  logic [CNT_W:0]   lim_w;
  logic [CNT_W-1:0] smp_lim;
  logic [IDX_W-1:0] msb_idx;

  assign busy   = (phase != PH_IDLE);
  assign accept = !busy && (start_std || start_inj);

  always_comb begin
    cfg_d  = cfg_q;
    inj_d  = inj_q;
    mode_d = mode_q;
    if (accept) begin
      cfg_d = start_inj ? inj_timing : std_timing;
      inj_d = start_inj;
    end
    if (mode_wr && !busy) mode_d = mode_wdata;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      cfg_q  <= '0;
      inj_q  <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      inj_q  <= inj_d;
      mode_q <= mode_d;
    end
  end

  always_comb begin
    res8    = cfg_q[CFG_W-1];
    div_lim = cfg_q[SMP_W +: DIV_W];
    smp_cnt = cfg_q[SMP_W-1:0];
    lim_w   = (((CNT_W+1)'(smp_cnt) + ONE_W) << UNIT_W) - ONE_W;
    smp_lim = lim_w[CNT_W-1:0];
    msb_idx = res8 ? MSB_LO : MSB_HI;
  end

  adc_bc_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .run     (busy),
    .div_lim (div_lim),
    .tick    (tick)
  );

  adc_phase_ctrl #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_phase (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .accept    (accept),
    .tick      (tick),
    .smp_lim   (smp_lim),
    .msb_idx   (msb_idx),
    .phase     (phase),
    .step_idx  (step_idx),
    .step_tick (step_tick),
    .last_step (last_step)
  );

  adc_sar_reg #(.RES_W(RES_HI), .IDX_W(IDX_W)) u_sar (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .clear     (accept),
    .active    (phase == PH_CONV),
    .step_tick (step_tick),
    .last_step (last_step),
    .idx       (step_idx),
    .cmp       (cmp_in),
    .trial     (sar_code_o),
    .result    (result_o),
    .done      (done_o)
  );

  assign busy_o       = busy;
  assign sample_o     = (phase == PH_SAMPLE);
  assign inj_active_o = busy && inj_q;
  assign mode_o       = mode_q;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             sample,
  input logic             done,
  input logic             mode,
  input logic [RES_W-1:0] trial,
  input logic [RES_W-1:0] result
);
  p_sample_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sample |-> busy);
  p_busy_opens_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> sample);
  p_steps_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sample) |-> busy);
  p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
  p_mode_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(mode));
  p_trial_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample || !busy) |-> (trial == '0));
endmodule

bind adc_seq_timer adc_seq_chk #(.RES_W(RES_HI)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .busy   (busy_o),
  .sample (sample_o),
  .done   (done_o),
  .mode   (mode_o),
  .trial  (sar_code_o),
  .result (result_o)
);

// File: tb/sim_adc_seq_timer.sv
module sim_adc_seq_timer;
  localparam int CLK_T = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] std_w = '0, inj_w = '0;
  logic        start_std = 1'b0, start_inj = 1'b0;
  logic        mode_wr = 1'b0, mode_wdata = 1'b0;
  logic        cmp_in;
  logic        mode_o, busy_o, sample_o, inj_active_o, done_o;
  logic [9:0]  sar_code_o, result_o;
  logic [9:0]  analog_v = '0;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_T/2) clk = ~clk;

  // comparator model: 1 when the analog value reaches the trial code
  assign cmp_in = (analog_v >= sar_code_o);

  adc_seq_timer u0 (
    .clk(clk), .rst_n(rst_n), .std_timing(std_w), .inj_timing(inj_w),
    .start_std(start_std), .start_inj(start_inj), .mode_wr(mode_wr),
    .mode_wdata(mode_wdata), .cmp_in(cmp_in), .mode_o(mode_o),
    .busy_o(busy_o), .sample_o(sample_o), .inj_active_o(inj_active_o),
    .done_o(done_o), .sar_code_o(sar_code_o), .result_o(result_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int f_sample_len(int d, int s);
    return 4 * (s + 1) * (d + 1);
  endfunction
  function automatic int f_busy_len(int d, int s, bit r8);
    return (4 * (s + 1) + (r8 ? 8 : 10)) * (d + 1);
  endfunction
  function automatic int f_result(int v, bit r8);
    if (r8) return (v > 255) ? 255 : v;
    return v;
  endfunction

  task automatic run_conv(input bit use_inj, input bit both, input int d,
                          input int s, input bit r8, input int v,
                          input bit perturb);
    int   nb = 0, ns = 0, res = 0, k = 0;
    bit   seen = 0;
    bit   mode_before;
    logic [12:0] prof, alt;
    prof = {r8, d[5:0], s[5:0]};
    alt  = 13'($urandom());
    @(negedge clk);
    analog_v    = v[9:0];
    mode_before = mode_o;
    if (use_inj) begin inj_w = prof; std_w = alt; end
    else         begin std_w = prof; inj_w = alt; end
    start_inj = use_inj;
    start_std = !use_inj || both;
    @(negedge clk);
    start_std = 1'b0;
    start_inj = 1'b0;
    while (!seen && k < 20000) begin
      if (k == 0) chk("R7 profile in use", int'(inj_active_o), int'(use_inj));
      if (busy_o)   nb++;
      if (sample_o) ns++;
      if (done_o) begin
        seen = 1;
        res  = int'(result_o);
        chk("R9 busy low at done", int'(busy_o), 0);
      end
      if (perturb && k == 2) begin
        std_w = 13'($urandom()); inj_w = 13'($urandom());
        start_std = 1'b1; start_inj = 1'b1;
        mode_wr = 1'b1; mode_wdata = ~mode_o;
      end else if (perturb && k == 3) begin
        start_std = 1'b0; start_inj = 1'b0; mode_wr = 1'b0;
      end
      k++;
      if (!seen) @(negedge clk);
    end
    chk(perturb ? "R3/R8 sample length" : "R3 sample length", ns, f_sample_len(d, s));
    chk(perturb ? "R2/R8 busy length"   : "R4 busy length",   nb, f_busy_len(d, s, r8));
    chk(r8 ? "R6 8-bit result" : "R5 10-bit result", res, f_result(v, r8));
    @(negedge clk);
    chk("R9 done one cycle", int'(done_o), 0);
    chk("R9 result held", int'(result_o), res);
    if (perturb) chk("R10 mode write while busy", int'(mode_o), int'(mode_before));
  endtask

  task automatic mode_write(input bit val);
    @(negedge clk);
    mode_wr = 1'b1; mode_wdata = val;
    @(negedge clk);
    mode_wr = 1'b0;
    chk("R10 mode write when idle", int'(mode_o), int'(val));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 busy in reset",   int'(busy_o),   0);
    chk("R1 sample in reset", int'(sample_o), 0);
    chk("R1 done in reset",   int'(done_o),   0);
    chk("R1 result in reset", int'(result_o), 0);
    chk("R1 mode in reset",   int'(mode_o),   0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after release", int'(busy_o), 0);
    chk("R1 trial code idle",    int'(sar_code_o), 0);

    // directed corners
    run_conv(0, 0, 0, 0, 0, 0,    0);
    run_conv(0, 0, 0, 0, 0, 1023, 0);
    run_conv(1, 0, 1, 0, 0, 512,  0);
    run_conv(0, 0, 0, 1, 1, 255,  0);
    run_conv(1, 0, 2, 0, 1, 300,  0);
    run_conv(0, 0, 0, 0, 1, 0,    0);
    run_conv(1, 1, 1, 1, 0, 341,  0);   // both requested: injected wins
    run_conv(0, 0, 1, 0, 0, 682,  1);   // disturbed while busy
    mode_write(1'b1);
    run_conv(1, 0, 0, 2, 1, 170,  1);
    mode_write(1'b0);
    run_conv(0, 0, 63, 63, 0, 777, 0);  // longest profile

    // random mix
    for (int i = 0; i < 40; i++) begin
      bit ui, bo, r8, pt;
      int d, s, v;
      ui = 1'($urandom()); bo = 1'($urandom()); r8 = 1'($urandom());
      pt = 1'($urandom());
      d  = int'($urandom() % 8); s = int'($urandom() % 8);
      v  = int'($urandom() % 1024);
      run_conv(ui, bo && ui, d, s, r8, v, pt);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule